// File: doc/BRIEF.md
# Three-State Current-Source Bridge Modulator

This block drives the seven switches of a three-phase current-source bridge that has an extra switch for circulating the link current: three upper devices, three lower devices and the circulating device. A symmetric up/down carrier is compared against six reference levels, arranged as two rows of three, one column per phase leg. The two rows compare with opposite polarity. A leg therefore reads as an all-ones column while the carrier lies between its lower-row level and its upper-row level. That column inserts a circulating interval at a state boundary without moving the edges of any active interval.

Every clock the six comparison bits are decoded into exactly one bridge request. The request is either a null state (upper and lower device of one leg), an active state (upper device of one leg, lower device of another) or the circulating state (circulating device alone). The request is registered and valid on every cycle; the downstream commutation stage cannot stall it. A host writes the reference levels and the carrier peak into shadow registers. The references become active only at carrier turning points, and the peak only at carrier zero. Bit patterns that match no state hold the bridge in its last null leg and set a sticky error flag.

Leg order everywhere is bit 0 = leg A, bit 1 = leg B, bit 2 = leg C. The next leg of A is B, of B is C, and of C is A.

Top module: `tristate_csi_mod`

## Requirements
- R1: The carrier starts at 0 after reset, steps by exactly one each clock from 0 up to the active peak and back down to 0, and so has a period of 2*peak cycles. Writing address 6 sets the peak shadow (a value of 0 is stored as 1); the shadow becomes the active peak when the carrier is at 0. The reset peak is PEAK_RST.
- R2: Addresses 0..2 hold the upper-row levels of legs A..C and addresses 3..5 hold the lower-row levels. Upper bit = (level >= carrier) and lower bit = (carrier >= level), so equality gives 1 in both rows.
- R3: All six levels load together from their shadows only on a cycle whose carrier is 0 or the peak. A write at any other time leaves the comparison unchanged until that point.
- R4: If any leg has both bits at 1, the request is the circulating device alone (up=000, dn=000, fw=1). Every request appears on the outputs one clock after the carrier value it was compared against.
- R5: If the lower row is the bitwise inverse of the upper row and the upper row has a single 1 at leg p, the request is up=p, dn=next(p). If the upper row has a single 0 at leg q, the request is dn=q, up=next(q).
- R6: If the upper row is 000 and the lower row is 111, the request is a null on the upper leg of the most recent active request. If the upper row is 111 and the lower row is 000, the request is a null on the lower leg of the most recent active request. After reset the most recent active request counts as up=A, dn=B.
- R7: Any other pattern produces a null on the leg of the most recent null request (leg A after reset) and sets the error flag. The flag stays set until reset.
- R8: While reset is held, the outputs are carrier 0, up=001, dn=001, fw=0 and error 0.
- R9: Every request has exactly one upper and one lower device on with fw=0, or fw=1 with no bridge device on.
- R10: A write to address 7 changes neither the carrier nor the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address (0..5 levels, 6 peak) |
| host_wdata | input | CW | Write data |
| carrier_o | output | CW | Current carrier value |
| gate_up | output | 3 | Upper device requests, one bit per leg |
| gate_dn | output | 3 | Lower device requests, one bit per leg |
| gate_fw | output | 1 | Circulating device request |
| decode_err | output | 1 | Sticky flag for an undecodable pattern |

## Verification
A wrong remembered active leg shows one clock after the next null pattern, as a null on the wrong leg. A wrong remembered null leg only shows when an undecodable pattern arrives. A level loaded off a turning point shows as a request changing in the middle of a half period, within one clock of the compare. A miscounted carrier or a peak loaded at the wrong time shows directly on carrier_o, as a skipped step or a period that is not 2*peak.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int NLEG      = 3;
  localparam int NREF      = 2 * NLEG;
  localparam int PEAK_ADDR = NREF;
  localparam int ADDR_W    = $clog2(NREF + 1);

  typedef logic [NLEG-1:0] leg_t;

  typedef struct packed {
    leg_t up;
    leg_t dn;
    logic fw;
  } gate_t;

  typedef enum logic [1:0] {K_FREE, K_ACTIVE, K_NULL, K_BAD} kind_e;

  localparam leg_t LEG_A = leg_t'(1);
  localparam leg_t LEG_B = leg_t'(2);

  function automatic leg_t leg_next(leg_t v);
    return {v[NLEG-2:0], v[NLEG-1]};
  endfunction
endpackage

// File: rtl/tsm_carrier.sv
module tsm_carrier #(
  parameter int CW       = 8,
  parameter int PEAK_RST = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          peak_we,
  input  logic [CW-1:0] peak_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] peak_act,
  output logic          turn
);
  localparam logic [CW-1:0] PEAK_INIT = CW'(PEAK_RST);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic          rising;
  logic [CW-1:0] peak_sh;

  // turning points: the bottom, or the top while rising
  assign turn = (cnt == '0) || (rising && (cnt >= peak_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rising   <= 1'b1;
      peak_sh  <= PEAK_INIT;
      peak_act <= PEAK_INIT;
    end else begin
      if (peak_we) peak_sh <= (peak_wdata == '0) ? ONE : peak_wdata;
      if (cnt == '0) begin
        peak_act <= peak_sh;
        cnt      <= ONE;
        rising   <= 1'b1;
      end else if (rising) begin
        if (cnt >= peak_act) begin
          cnt    <= cnt - ONE;
          rising <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/tsm_refbank.sv
module tsm_refbank
  import tsm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CW-1:0]        wdata,
  input  logic                 load,
  output logic [NREF*CW-1:0]   ref_flat
);
  for (genvar i = 0; i < NREF; i++) begin : g_slot
    logic [CW-1:0] shadow;
    logic [CW-1:0] live;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow <= '0;
        live   <= '0;
      end else begin
        if (we && (addr == ADDR_W'(i))) shadow <= wdata;
        if (load) live <= shadow;
      end
    end

    assign ref_flat[i*CW +: CW] = live;
  end
endmodule

// File: rtl/tsm_compare.sv
module tsm_compare
  import tsm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0]      cnt,
  input  logic [NREF*CW-1:0] ref_flat,
  output leg_t               top_bits,
  output leg_t               bot_bits
);
  for (genvar l = 0; l < NLEG; l++) begin : g_leg
    logic [CW-1:0] hi_lvl;
    logic [CW-1:0] lo_lvl;
    assign hi_lvl      = ref_flat[l*CW +: CW];
    assign lo_lvl      = ref_flat[(NLEG+l)*CW +: CW];
    // opposite polarity per row; equality reads as 1 in both
    assign top_bits[l] = (hi_lvl >= cnt);
    assign bot_bits[l] = (cnt >= lo_lvl);
  end
endmodule

// File: rtl/tsm_decode.sv
module tsm_decode
  import tsm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  leg_t  top_bits,
  input  leg_t  bot_bits,
  output gate_t gate,
  output logic  err
);
  leg_t  last_up;
  leg_t  last_dn;
  leg_t  null_leg;
  kind_e kind;
  gate_t nxt;

  always_comb begin
    kind = K_BAD;
    nxt  = '{up: null_leg, dn: null_leg, fw: 1'b0};
    if (|(top_bits & bot_bits)) begin
      kind = K_FREE;
      nxt  = '{up: '0, dn: '0, fw: 1'b1};
    end else if (bot_bits == ~top_bits) begin
      if (top_bits == '0) begin
        kind = K_NULL;
        nxt  = '{up: last_up, dn: last_up, fw: 1'b0};
      end else if (top_bits == '1) begin
        kind = K_NULL;
        nxt  = '{up: last_dn, dn: last_dn, fw: 1'b0};
      end else if ($countones(top_bits) == 1) begin
        kind = K_ACTIVE;
        nxt  = '{up: top_bits, dn: leg_next(top_bits), fw: 1'b0};
      end else begin
        kind = K_ACTIVE;
        nxt  = '{up: leg_next(~top_bits), dn: ~top_bits, fw: 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate     <= '{up: LEG_A, dn: LEG_A, fw: 1'b0};
      last_up  <= LEG_A;
      last_dn  <= LEG_B;
      null_leg <= LEG_A;
      err      <= 1'b0;
    end else begin
      gate <= nxt;
      case (kind)
        K_ACTIVE: begin
          last_up <= nxt.up;
          last_dn <= nxt.dn;
        end
        K_NULL:  null_leg <= nxt.up;
        K_BAD:   err <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tristate_csi_mod.sv
module tristate_csi_mod
  import tsm_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PEAK_RST = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CW-1:0]     host_wdata,
  output logic [CW-1:0]     carrier_o,
  output logic [NLEG-1:0]   gate_up,
  output logic [NLEG-1:0]   gate_dn,
  output logic              gate_fw,
  output logic              decode_err
);
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      peak_act;
  logic               turn;
  logic               peak_we;
  logic [NREF*CW-1:0] ref_act_flat;
  leg_t               top_bits;
  leg_t               bot_bits;
  gate_t              gate;

  assign peak_we = host_we && (host_addr == ADDR_W'(PEAK_ADDR));

  tsm_carrier #(.CW(CW), .PEAK_RST(PEAK_RST)) u_carrier (
    .clk        (clk),
    .rst        (rst),
    .peak_we    (peak_we),
    .peak_wdata (host_wdata),
    .cnt        (cnt),
    .peak_act   (peak_act),
    .turn       (turn)
  );

  tsm_refbank #(.CW(CW)) u_refs (
    .clk      (clk),
    .rst      (rst),
    .we       (host_we),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .load     (turn),
    .ref_flat (ref_act_flat)
  );

  tsm_compare #(.CW(CW)) u_cmp (
    .cnt      (cnt),
    .ref_flat (ref_act_flat),
    .top_bits (top_bits),
    .bot_bits (bot_bits)
  );

  tsm_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .top_bits (top_bits),
    .bot_bits (bot_bits),
    .gate     (gate),
    .err      (decode_err)
  );

  assign carrier_o = cnt;
  assign gate_up   = gate.up;
  assign gate_dn   = gate.dn;
  assign gate_fw   = gate.fw;
endmodule

// File: rtl/tristate_csi_mod_chk.sv
module tristate_csi_mod_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   carrier,
  input logic [CW-1:0]   peak,
  input logic [6*CW-1:0] ref_flat,
  input logic [2:0]      top_bits,
  input logic [2:0]      bot_bits,
  input logic [2:0]      gate_up,
  input logic [2:0]      gate_dn,
  input logic            gate_fw,
  input logic            decode_err
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r9_gate_form: assert property (@(posedge clk) disable iff (rst)
    (gate_fw && gate_up == 3'b000 && gate_dn == 3'b000) ||
    (!gate_fw && $countones(gate_up) == 1 && $countones(gate_dn) == 1));

  a_r4_free_follows: assert property (@(posedge clk) disable iff (rst)
    (|(top_bits & bot_bits)) |=> gate_fw);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    decode_err |=> decode_err);

  a_r1_carrier_step: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (carrier == CW'($past(carrier) + 1'b1)) ||
                (carrier == CW'($past(carrier) - 1'b1)));

  a_r1_carrier_bound: assert property (@(posedge clk) disable iff (rst)
    carrier <= peak);

  a_r3_refs_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(carrier) != '0 && $past(carrier) != $past(peak))
      |-> $stable(ref_flat));
endmodule

bind tristate_csi_mod tristate_csi_mod_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .carrier    (carrier_o),
  .peak       (peak_act),
  .ref_flat   (ref_act_flat),
  .top_bits   (top_bits),
  .bot_bits   (bot_bits),
  .gate_up    (gate_up),
  .gate_dn    (gate_dn),
  .gate_fw    (gate_fw),
  .decode_err (decode_err)
);

// File: tb/tristate_csi_mod_test.sv
module tristate_csi_mod_test;
  localparam int CW = 8;
  localparam logic [7:0] HI = 8'hFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_we = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [CW-1:0] host_wdata = '0;
  logic [CW-1:0] carrier_o;
  logic [2:0]    gate_up, gate_dn;
  logic          gate_fw, decode_err;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  tristate_csi_mod #(.CW(CW), .PEAK_RST(15)) uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .carrier_o(carrier_o), .gate_up(gate_up),
    .gate_dn(gate_dn), .gate_fw(gate_fw), .decode_err(decode_err));

  // {upper row C B A, lower row C B A, up, dn, fw, err}
  localparam logic [13:0] VEC [14] = '{
    {3'b000, 3'b111, 3'b001, 3'b001, 1'b0, 1'b0},
    {3'b001, 3'b110, 3'b001, 3'b010, 1'b0, 1'b0},
    {3'b011, 3'b100, 3'b001, 3'b100, 1'b0, 1'b0},
    {3'b111, 3'b000, 3'b100, 3'b100, 1'b0, 1'b0},
    {3'b010, 3'b101, 3'b010, 3'b100, 1'b0, 1'b0},
    {3'b110, 3'b001, 3'b010, 3'b001, 1'b0, 1'b0},
    {3'b000, 3'b111, 3'b010, 3'b010, 1'b0, 1'b0},
    {3'b100, 3'b011, 3'b100, 3'b001, 1'b0, 1'b0},
    {3'b101, 3'b010, 3'b100, 3'b010, 1'b0, 1'b0},
    {3'b111, 3'b000, 3'b010, 3'b010, 1'b0, 1'b0},
    {3'b001, 3'b001, 3'b000, 3'b000, 1'b1, 1'b0},
    {3'b110, 3'b110, 3'b000, 3'b000, 1'b1, 1'b0},
    {3'b101, 3'b000, 3'b010, 3'b010, 1'b0, 1'b1},
    {3'b000, 3'b111, 3'b100, 3'b100, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_c(input logic [CW-1:0] v);
    int n = 0;
    @(negedge clk);
    while (carrier_o !== v && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) check("R1 carrier reach", 32'(carrier_o), 32'(v));
  endtask

  task automatic period(input string tag, input int exp);
    int n = 0;
    wait_c(0);
    @(negedge clk); n++;
    while (carrier_o !== '0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(tag, n, exp);
  endtask

  function automatic logic [31:0] gates();
    return {25'd0, gate_up, gate_dn, gate_fw};
  endfunction

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] g0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 carrier", 32'(carrier_o), 0);
    check("R8 gates", gates(), {25'd0, 3'b001, 3'b001, 1'b0});
    check("R8 err", 32'(decode_err), 0);
    rst = 1'b0;

    // table: R4 R5 R6 R7 patterns
    for (int k = 0; k < 14; k++) begin
      logic [2:0] t, b;
      string tag;
      t = VEC[k][13:11];
      b = VEC[k][10:8];
      wait_c(0);
      for (int l = 0; l < 3; l++) wr(3'(l), t[l] ? HI : 8'h00);
      for (int l = 0; l < 3; l++) wr(3'(3 + l), b[l] ? 8'h00 : HI);
      wait_c(15);
      wait_c(8);
      if (VEC[k][1]) tag = "R4 circulate";
      else if (VEC[k][0]) tag = "R7 fallback";
      else if (VEC[k][7:5] == VEC[k][4:2]) tag = "R6 null";
      else tag = "R5 active";
      check(tag, gates(), {25'd0, VEC[k][7:1]});
      check("R7 err flag", 32'(decode_err), 32'(VEC[k][0]));
    end

    // R2: equality on both rows gives a circulating slot at carrier 8
    wait_c(0);
    wr(0, 8); wr(1, 0); wr(2, 0); wr(3, 8); wr(4, 0); wr(5, 0);
    wait_c(15);
    wait_c(0);
    wait_c(8);
    check("R2 below level", gates(), {25'd0, 3'b001, 3'b010, 1'b0});
    @(negedge clk);
    check("R2 at level", gates(), {25'd0, 3'b000, 3'b000, 1'b1});
    @(negedge clk);
    check("R2 above level", gates(), {25'd0, 3'b001, 3'b001, 1'b0});

    // R3: write mid half-period is held until the next turning point
    wait_c(3);
    wr(0, 0);
    check("R3 held", gates(), {25'd0, 3'b001, 3'b010, 1'b0});
    wait_c(5);
    check("R3 loaded", gates(), {25'd0, 3'b001, 3'b001, 1'b0});

    // R1: programmable peak
    wr(6, 5);
    wait_c(0);
    wait_c(5);
    @(negedge clk);
    check("R1 turn at peak", 32'(carrier_o), 4);
    period("R1 period peak 5", 10);
    wr(6, 0);
    wait_c(0);
    period("R1 zero stored as 1", 2);

    // R10: unused address
    wait_c(1);
    g0 = gates();
    wr(7, 8'h03);
    period("R10 period kept", 2);
    wait_c(1);
    check("R10 gates kept", gates(), g0);

    // R7 / R8: reset clears flag and restores state
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 reset clears err", 32'(decode_err), 0);
    check("R8 gates after reset", gates(), {25'd0, 3'b001, 3'b001, 1'b0});
    check("R8 carrier after reset", 32'(carrier_o), 0);
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule